// File: doc/BRIEF.md
# Mode-Gated Radio Interrupt Controller

This block collects event pulses from a radio core into one interrupt line. Events fall into three groups: transmit, receive and system. Every source has its own sticky status bit and its own enable bit. A source can raise the line only when its status bit is set and its enable bit is set. The radio's operating mode must also let its group through.

While the radio is transmitting, the receive group is held off. While it is receiving, the transmit group is held off. The system group passes in every mode. The stored enable bits never change because the mode changes, so returning to the other mode restores the earlier masking. Status bits can be read at any time, whether or not they are enabled, so a host can poll instead of waiting on the line.

The line's active level is programmable, and so is its drive style: push-pull, or open-drain emulated through an output-enable. A host reaches all state through a small synchronous register port. Reading a status register clears it.

Top module: `radio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on any bit of `tx_evt_i`, `rx_evt_i` or `sys_evt_i` sets the matching status bit at that clock edge. The bit then stays set until its status register is read.
- R2: A read (`rd_en_i`=1) of address 0 (transmit status), 1 (receive status) or 2 (system status) returns the bits held before that edge on `rdata_o` one cycle later, right-aligned, and clears them. An event arriving in the same cycle as that read is absent from the returned data and stays set afterwards.
- R3: A status bit is set and readable even when its enable bit is 0, and a disabled source never asserts the interrupt.
- R4: Enable registers sit at addresses 4 (transmit), 5 (receive) and 6 (system), bit i enabling source i. Each bit is written independently and reads back as written. Address 3 reads as zero.
- R5: With `mode_i`=2'b01 (transmit), receive sources cannot assert the interrupt. With `mode_i`=2'b10 (receive), transmit sources cannot. With 2'b00 or 2'b11 (idle), both groups can.
- R6: Changing `mode_i` never alters the contents of the enable registers.
- R7: System sources assert the interrupt regardless of `mode_i`.
- R8: The internal interrupt request is the OR over all sources of status AND enable AND mode gate. It is registered, so the pin reflects the state one clock edge after that state is present.
- R9: The pin configuration register at address 7 uses bit 0 for the active level (1 = active high) and bit 1 for the drive style. With push-pull drive, `irq_o` equals the active level when the request is asserted and its inverse otherwise.
- R10: When bit 1 of address 7 is 1 (open drain), `irq_oe_o` is 1 only while the request is asserted, and `irq_o` always carries the active level. When bit 1 is 0 (push-pull), `irq_oe_o` stays 1.
- R11: After synchronous reset, all status and enable bits are 0, `rdata_o` is 0 and the pin configuration is active-high push-pull. As a result `irq_o`=0 and `irq_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_evt_i | input | N_TX | Transmit event pulses |
| rx_evt_i | input | N_RX | Receive event pulses |
| sys_evt_i | input | N_SYS | System event pulses |
| mode_i | input | 2 | Radio mode: 00/11 idle, 01 transmit, 10 receive |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Interrupt pin level |
| irq_oe_o | output | 1 | Interrupt pin output-enable |

## Verification
Two things can land in the same cycle: the clear caused by a status read, and a new event on a source of that register. The bench provokes this collision directly, by pulsing an event during the read strobe. It also occurs many times under random stimulus, where sparse event pulses overlap random status reads. For each collision, the value returned by the read must exclude the new event, and a later read must still return that event. Mode changes landing in the same cycle as a pending request are judged against a bench model that gates each group by the mode sampled at the edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'b00,
        MODE_TX     = 2'b01,
        MODE_RX     = 2'b10,
        MODE_IDLE_B = 2'b11
    } radio_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TX_ST  = 3'd0,
        SEL_RX_ST  = 3'd1,
        SEL_SYS_ST = 3'd2,
        SEL_NONE   = 3'd3,
        SEL_TX_EN  = 3'd4,
        SEL_RX_EN  = 3'd5,
        SEL_SYS_EN = 3'd6,
        SEL_PIN    = 3'd7
    } reg_sel_e;

    // bit 1: open drain, bit 0: active high
    typedef struct packed {
        logic open_drain;
        logic act_high;
    } pin_cfg_t;

    localparam pin_cfg_t PIN_CFG_RST = '{open_drain: 1'b0, act_high: 1'b1};

    function automatic logic tx_group_open(radio_mode_e m);
        return m != MODE_RX;
    endfunction

    function automatic logic rx_group_open(radio_mode_e m);
        return m != MODE_TX;
    endfunction

endpackage

// File: rtl/irqc_sticky.sv
module irqc_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr,
    output logic [W-1:0] st
);

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= (clr ? '0 : st) | evt;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((st & $past(st)) == $past(st)));                    // R1
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((st & $past(evt)) == $past(evt)));                 // R1
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> (st == '0));                            // R2

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int N_TX  = 4,
    parameter int N_RX  = 4,
    parameter int N_SYS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [N_TX-1:0]   tx_st,
    input  logic [N_RX-1:0]   rx_st,
    input  logic [N_SYS-1:0]  sys_st,
    output logic [N_TX-1:0]   tx_en,
    output logic [N_RX-1:0]   rx_en,
    output logic [N_SYS-1:0]  sys_en,
    output pin_cfg_t          cfg,
    output logic              clr_tx,
    output logic              clr_rx,
    output logic              clr_sys,
    output logic [DW-1:0]     rdata
);

    reg_sel_e      sel;
    logic [DW-1:0] rd_mux;
    logic          unused_wdata;

    assign sel          = reg_sel_e'(addr);
    assign unused_wdata = ^wdata;

    assign clr_tx  = rd_en && (sel == SEL_TX_ST);
    assign clr_rx  = rd_en && (sel == SEL_RX_ST);
    assign clr_sys = rd_en && (sel == SEL_SYS_ST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en  <= '0;
            rx_en  <= '0;
            sys_en <= '0;
            cfg    <= PIN_CFG_RST;
        end else if (wr_en) begin
            case (sel)
                SEL_TX_EN:  tx_en  <= wdata[N_TX-1:0];
                SEL_RX_EN:  rx_en  <= wdata[N_RX-1:0];
                SEL_SYS_EN: sys_en <= wdata[N_SYS-1:0];
                SEL_PIN:    cfg    <= pin_cfg_t'(wdata[1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_TX_ST:  rd_mux[N_TX-1:0]  = tx_st;
            SEL_RX_ST:  rd_mux[N_RX-1:0]  = rx_st;
            SEL_SYS_ST: rd_mux[N_SYS-1:0] = sys_st;
            SEL_TX_EN:  rd_mux[N_TX-1:0]  = tx_en;
            SEL_RX_EN:  rd_mux[N_RX-1:0]  = rx_en;
            SEL_SYS_EN: rd_mux[N_SYS-1:0] = sys_en;
            SEL_PIN:    rd_mux[1:0]       = cfg;
            default:    rd_mux            = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_ENABLES_KEPT: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(tx_en) && $stable(rx_en) && $stable(sys_en))); // R6

endmodule

// File: rtl/irqc_combine.sv
module irqc_combine
    import irqc_pkg::*;
#(
    parameter int N_TX  = 4,
    parameter int N_RX  = 4,
    parameter int N_SYS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  radio_mode_e      mode,
    input  logic [N_TX-1:0]  tx_st,
    input  logic [N_RX-1:0]  rx_st,
    input  logic [N_SYS-1:0] sys_st,
    input  logic [N_TX-1:0]  tx_en,
    input  logic [N_RX-1:0]  rx_en,
    input  logic [N_SYS-1:0] sys_en,
    output logic             irq_active
);

    logic tx_req, rx_req, sys_req, req;

    assign tx_req  = tx_group_open(mode) && |(tx_st & tx_en);
    assign rx_req  = rx_group_open(mode) && |(rx_st & rx_en);
    assign sys_req = |(sys_st & sys_en);
    assign req     = tx_req || rx_req || sys_req;

    always_ff @(posedge clk) begin
        if (rst) irq_active <= 1'b0;
        else     irq_active <= req;
    end

    AST_RX_HELD_IN_TX: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TX && (tx_st & tx_en) == '0 && (sys_st & sys_en) == '0)
        |=> !irq_active);                                             // R5
    AST_TX_HELD_IN_RX: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RX && (rx_st & rx_en) == '0 && (sys_st & sys_en) == '0)
        |=> !irq_active);                                             // R5
    AST_SYS_UNGATED: assert property (@(posedge clk) disable iff (rst)
        (|(sys_st & sys_en)) |=> irq_active);                          // R7
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tx_en == '0 && rx_en == '0 && sys_en == '0) |=> !irq_active); // R3

endmodule

// File: rtl/irqc_pin_drv.sv
module irqc_pin_drv
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     irq_active,
    input  pin_cfg_t cfg,
    output logic     irq_o,
    output logic     irq_oe_o
);

    always_comb begin
        if (cfg.open_drain) begin
            irq_o    = cfg.act_high;
            irq_oe_o = irq_active;
        end else begin
            irq_o    = irq_active ? cfg.act_high : !cfg.act_high;
            irq_oe_o = 1'b1;
        end
    end

    AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        !cfg.open_drain |-> irq_oe_o);                                 // R10
    AST_OD_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (cfg.open_drain && !irq_active) |-> !irq_oe_o);                // R10
    AST_LEVEL_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        irq_active |-> (irq_o == cfg.act_high));                       // R9

endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int N_TX  = 4,
    parameter int N_RX  = 4,
    parameter int N_SYS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_TX-1:0]  tx_evt_i,
    input  logic [N_RX-1:0]  rx_evt_i,
    input  logic [N_SYS-1:0] sys_evt_i,
    input  logic [1:0]       mode_i,
    input  logic             rd_en_i,
    input  logic             wr_en_i,
    input  logic [2:0]       addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             irq_o,
    output logic             irq_oe_o
);

    logic [N_TX-1:0]  tx_st, tx_en;
    logic [N_RX-1:0]  rx_st, rx_en;
    logic [N_SYS-1:0] sys_st, sys_en;
    logic             clr_tx, clr_rx, clr_sys;
    logic             irq_active;
    pin_cfg_t         cfg;
    radio_mode_e      mode;

    assign mode = radio_mode_e'(mode_i);

    irqc_sticky #(.W(N_TX)) u_tx_st (
        .clk(clk), .rst(rst), .evt(tx_evt_i), .clr(clr_tx), .st(tx_st));
    irqc_sticky #(.W(N_RX)) u_rx_st (
        .clk(clk), .rst(rst), .evt(rx_evt_i), .clr(clr_rx), .st(rx_st));
    irqc_sticky #(.W(N_SYS)) u_sys_st (
        .clk(clk), .rst(rst), .evt(sys_evt_i), .clr(clr_sys), .st(sys_st));

    irqc_regfile #(.DW(DW), .N_TX(N_TX), .N_RX(N_RX), .N_SYS(N_SYS)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i),
        .addr(addr_i), .wdata(wdata_i),
        .tx_st(tx_st), .rx_st(rx_st), .sys_st(sys_st),
        .tx_en(tx_en), .rx_en(rx_en), .sys_en(sys_en), .cfg(cfg),
        .clr_tx(clr_tx), .clr_rx(clr_rx), .clr_sys(clr_sys),
        .rdata(rdata_o));

    irqc_combine #(.N_TX(N_TX), .N_RX(N_RX), .N_SYS(N_SYS)) u_combine (
        .clk(clk), .rst(rst), .mode(mode),
        .tx_st(tx_st), .rx_st(rx_st), .sys_st(sys_st),
        .tx_en(tx_en), .rx_en(rx_en), .sys_en(sys_en),
        .irq_active(irq_active));

    irqc_pin_drv u_pin (
        .clk(clk), .rst(rst), .irq_active(irq_active), .cfg(cfg),
        .irq_o(irq_o), .irq_oe_o(irq_oe_o));

    AST_READ_NEEDED_TO_DROP: assert property (@(posedge clk) disable iff (rst)
        (!rd_en_i && (sys_st & sys_en) != '0) |=> ((sys_st & $past(sys_st)) == $past(sys_st))); // R1

endmodule

// File: tb/radio_irq_ctrl_tb.sv
module radio_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8, N_TX = 4, N_RX = 4, N_SYS = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N_TX-1:0]  tx_evt = '0;
    logic [N_RX-1:0]  rx_evt = '0;
    logic [N_SYS-1:0] sys_evt = '0;
    logic [1:0]       mode = 2'b00;
    logic             rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0]       addr = '0;
    logic [DW-1:0]    wdata = '0;
    logic [DW-1:0]    rdata;
    logic             irq_o, irq_oe;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // bench model
    logic [N_TX-1:0]  m_tx_st, m_tx_en;
    logic [N_RX-1:0]  m_rx_st, m_rx_en;
    logic [N_SYS-1:0] m_sys_st, m_sys_en;
    logic             m_od, m_ah, m_act;
    logic [DW-1:0]    m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    radio_irq_ctrl #(.DW(DW), .N_TX(N_TX), .N_RX(N_RX), .N_SYS(N_SYS)) u_dut (
        .clk(clk), .rst(rst), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
        .sys_evt_i(sys_evt), .mode_i(mode), .rd_en_i(rd_en), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq_o), .irq_oe_o(irq_oe));

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic exp_pin_o(logic act, logic od, logic ah);
        return od ? ah : (act ? ah : !ah);
    endfunction

    function automatic logic exp_pin_oe(logic act, logic od);
        return od ? act : 1'b1;
    endfunction

    function automatic logic [DW-1:0] model_read(logic [2:0] a);
        logic [DW-1:0] r;
        r = '0;
        case (a)
            3'd0: r[N_TX-1:0]  = m_tx_st;
            3'd1: r[N_RX-1:0]  = m_rx_st;
            3'd2: r[N_SYS-1:0] = m_sys_st;
            3'd4: r[N_TX-1:0]  = m_tx_en;
            3'd5: r[N_RX-1:0]  = m_rx_en;
            3'd6: r[N_SYS-1:0] = m_sys_en;
            3'd7: r[1:0]       = {m_od, m_ah};
            default: r = '0;
        endcase
        return r;
    endfunction

    // advance one clock; model follows; pins and pending read checked
    task automatic tick();
        logic tx_ok, rx_ok, n_act, was_rd;
        logic [2:0] rd_addr;
        logic [DW-1:0] n_rdata;
        tx_ok   = (mode != 2'b10);
        rx_ok   = (mode != 2'b01);
        n_act   = (tx_ok && |(m_tx_st & m_tx_en)) || (rx_ok && |(m_rx_st & m_rx_en))
                  || |(m_sys_st & m_sys_en);
        was_rd  = rd_en;
        rd_addr = addr;
        n_rdata = rd_en ? model_read(addr) : m_rdata;
        @(posedge clk);
        #1;
        if (rst) begin
            m_tx_st = '0; m_rx_st = '0; m_sys_st = '0;
            m_tx_en = '0; m_rx_en = '0; m_sys_en = '0;
            m_od = 1'b0; m_ah = 1'b1; m_act = 1'b0; m_rdata = '0;
        end else begin
            m_tx_st  = ((was_rd && rd_addr == 3'd0) ? '0 : m_tx_st)  | tx_evt;
            m_rx_st  = ((was_rd && rd_addr == 3'd1) ? '0 : m_rx_st)  | rx_evt;
            m_sys_st = ((was_rd && rd_addr == 3'd2) ? '0 : m_sys_st) | sys_evt;
            if (wr_en) begin
                case (addr)
                    3'd4: m_tx_en  = wdata[N_TX-1:0];
                    3'd5: m_rx_en  = wdata[N_RX-1:0];
                    3'd6: m_sys_en = wdata[N_SYS-1:0];
                    3'd7: {m_od, m_ah} = wdata[1:0];
                    default: ;
                endcase
            end
            m_act   = n_act;
            m_rdata = n_rdata;
            if (was_rd) chk((rd_addr <= 3'd2) ? "R2 status read" : "R4 register read", rdata, m_rdata);
        end
        chk(m_od ? "R10 pin level" : "R8 pin level", {7'd0, irq_o}, {7'd0, exp_pin_o(m_act, m_od, m_ah)});
        chk("R10 output enable", {7'd0, irq_oe}, {7'd0, exp_pin_oe(m_act, m_od)});
        tx_evt = '0; rx_evt = '0; sys_evt = '0;
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
    endtask

    task automatic rd(input logic [2:0] a);
        addr = a; rd_en = 1'b1;
        tick();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240613));
        #1;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R11: reset state
        chk("R11 irq level", {7'd0, irq_o}, 8'd0);
        chk("R11 irq oe", {7'd0, irq_oe}, 8'd1);
        chk("R11 rdata", rdata, 8'd0);
        rd(3'd7);
        chk("R11 pin cfg", rdata, 8'h01);

        // R3: status captured with enables off, no interrupt
        tx_evt = 4'b0101; tick();
        tick();
        chk("R3 disabled no irq", {7'd0, irq_o}, 8'd0);
        rd(3'd0);
        chk("R3 status readable", rdata, 8'h05);
        rd(3'd0);
        chk("R2 cleared by read", rdata, 8'h00);

        // R1: sticky across idle cycles
        sys_evt = 3'b010; tick();
        repeat (5) tick();
        rd(3'd2);
        chk("R1 sticky held", rdata, 8'h02);

        // R2: event collides with clearing read
        rx_evt = 4'b0001; tick();
        addr = 3'd1; rd_en = 1'b1; rx_evt = 4'b0010; tick();
        chk("R2 read excludes new event", rdata, 8'h01);
        rd(3'd1);
        chk("R2 colliding event kept", rdata, 8'h02);

        // R4: enables and address 3
        wr(3'd4, 8'hFF); wr(3'd5, 8'h0A); wr(3'd6, 8'h07);
        rd(3'd4); chk("R4 tx enable", rdata, 8'h0F);
        rd(3'd5); chk("R4 rx enable", rdata, 8'h0A);
        rd(3'd3); chk("R4 hole reads zero", rdata, 8'h00);
        wr(3'd5, 8'h0F);

        // R5: group gating by mode
        mode = 2'b01; rx_evt = 4'b0100; tick();
        tick();
        chk("R5 rx held in tx mode", {7'd0, irq_o}, 8'd0);
        mode = 2'b10; tick();
        chk("R5 rx passes in rx mode", {7'd0, irq_o}, 8'd1);
        rd(3'd1);
        tx_evt = 4'b1000; tick();
        tick();
        chk("R5 tx held in rx mode", {7'd0, irq_o}, 8'd0);
        mode = 2'b11; tick();
        chk("R5 idle passes tx", {7'd0, irq_o}, 8'd1);
        rd(3'd0);

        // R6: mode switching leaves enables
        mode = 2'b01; tick(); mode = 2'b10; tick(); mode = 2'b00; tick();
        rd(3'd4); chk("R6 tx enable kept", rdata, 8'h0F);
        rd(3'd5); chk("R6 rx enable kept", rdata, 8'h0F);

        // R7: system passes in both modes
        mode = 2'b01; sys_evt = 3'b001; tick(); tick();
        chk("R7 sys in tx mode", {7'd0, irq_o}, 8'd1);
        mode = 2'b10; tick();
        chk("R7 sys in rx mode", {7'd0, irq_o}, 8'd1);

        // R9: active low push-pull
        wr(3'd7, 8'h00);
        chk("R9 active low asserted", {7'd0, irq_o}, 8'd0);
        rd(3'd2); tick();
        chk("R9 active low idle", {7'd0, irq_o}, 8'd1);

        // R10: open drain active high
        wr(3'd7, 8'h03);
        chk("R10 od released", {7'd0, irq_oe}, 8'd0);
        sys_evt = 3'b100; tick(); tick();
        chk("R10 od driven", {7'd0, irq_oe}, 8'd1);
        chk("R10 od level", {7'd0, irq_o}, 8'd1);
        rd(3'd2); tick();
        chk("R10 od released again", {7'd0, irq_oe}, 8'd0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            r = $urandom;
            tx_evt  = 4'($urandom & $urandom & $urandom);
            rx_evt  = 4'($urandom & $urandom & $urandom);
            sys_evt = 3'($urandom & $urandom & $urandom);
            if (r[3:0] == 4'd0) mode = 2'($urandom);
            if (r[6:4] == 3'd0) begin
                addr = 3'($urandom); rd_en = 1'b1;
            end else if (r[10:7] == 4'd0) begin
                addr = 3'($urandom); wdata = 8'($urandom); wr_en = 1'b1;
            end else if (r[13:11] == 3'd1) begin
                addr = 3'($urandom % 3); rd_en = 1'b1;
            end
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule